// File: doc/BRIEF.md
# Pattern-Table Bank Address Generator

This block turns a set of banking registers into the physical 1 KiB pattern-table bank number for each of the eight 1 KiB windows that make up the 8 KiB video address space. It combines an outer bank, which selects an 8 KiB region, with inner 1 KiB bank registers through a mask chosen by the mode register. A whole-region mode ignores the inner registers and maps the eight windows onto eight consecutive banks. In that mode an optional discrete data latch can supply the low bits of the region number.

The eight bank numbers are registered once per clock from the current register values. A combinational lookup returns the registered bank of the window that the video address bits 12:10 select. The memory arrays, nametable handling and any RAM/ROM split are outside this block.

Internally a decoder sorts every cycle into one of three map modes: NORMAL, EXTENDED and WHOLE8K. The mode changes whenever the mode or extension register changes. There is no transition ordering: the mode is a pure function of the current register bits. WHOLE8K takes priority over EXTENDED, and EXTENDED takes priority over NORMAL.

Top module: `chr_bank_gen`

## Requirements
- R1: While `rst_n` is low, every registered window bank is zero, and `bank_lookup` is zero as well.
- R2: A change on any register input appears in `win_bank` after exactly one rising clock edge. `bank_lookup` always equals `win_bank[ppu_a]`, with `ppu_a` being video address bits 12:10.
- R3: In NORMAL mode (`mode_reg` bit 6 clear and `ext_reg` bit 1 clear, invert clear), window 0 uses slot register 0 with bit 0 forced to 0. Window 1 uses slot register 0 with bit 0 forced to 1. Windows 2 and 3 follow the same rule with slot register 1.
- R4: Outside WHOLE8K, the inner mask is 0x7F when `mode_reg` bit 4 is set and 0xFF when it is clear. The bank is (inner AND mask) OR (({outer,3'b000}) AND NOT mask), computed 11 bits wide. In NORMAL mode with invert clear, windows 4 to 7 use slot registers 2 to 5.
- R5: In EXTENDED mode (`mode_reg` bit 6 clear, `ext_reg` bit 1 set), windows 0 to 7 take slot registers 0, 6, 1, 7, 2, 3, 4, 5 unaltered, with the same masking as R4. Slots 6 and 7 are the two registers that only this mode uses.
- R6: Outside WHOLE8K, when `ctrl_reg` bit 7 is set, window w takes the content that window w XOR 4 would have with the bit clear. This swaps the two 4 KiB halves.
- R7: In WHOLE8K mode (`mode_reg` bit 6 set), window n gets {base, n}, which is base*8+n. The inner registers and the invert bit have no effect in this mode.
- R8: In WHOLE8K mode the latch mask is 0x01 when `latch_present` is high, `mode_reg` bit 5 is clear and `mode_reg` bit 4 is set. It is 0x03 when `latch_present` is high and `mode_reg` bits 5 and 4 are both clear. Otherwise it is 0, and base then equals `outer_bank`.
- R9: With `or_variant` low, base = (outer AND NOT latch mask) OR (latch AND latch mask). With `or_variant` high, base = outer OR (latch AND latch mask).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inner_regs | input | 8x8 | Slot registers 0-7 (slots 6, 7 used only in EXTENDED mode) |
| ctrl_reg | input | 8 | Control byte; bit 7 swaps the 4 KiB halves |
| mode_reg | input | 8 | Bit 6 whole-8K, bit 5 latch disable, bit 4 small mask |
| ext_reg | input | 8 | Bit 1 selects EXTENDED mode |
| outer_bank | input | 8 | Outer 8 KiB bank |
| data_latch | input | 8 | Discrete latch value |
| latch_present | input | 1 | The board has the discrete latch |
| or_variant | input | 1 | Selects the OR variant for building the whole-8K base |
| ppu_a | input | 3 | Video address bits 12:10 |
| win_bank | output | 8x11 | Registered bank for each window |
| bank_lookup | output | 11 | Bank of the window selected by `ppu_a` |

## Verification
Two functions can act in the same cycle: the half-swap of R6 and the pairing or the extended reordering of R3 and R5. The sweep flips the invert bit together with the extension bit, the mask-size bit and the whole-8K bit. Each of the eight windows is then judged against a bank number that the bench computes arithmetically from the written rules. Latch masking and the outer bank also change in the same cycles as the mode bits. Every combination of the seven configuration bits is exercised with several data patterns, and each combination is checked both through the registered outputs and through the lookup at every address.

// File: rtl/chr_bank_pkg.sv
package chr_bank_pkg;

    typedef enum logic [1:0] {
        MAP_NORMAL   = 2'd0,
        MAP_EXTENDED = 2'd1,
        MAP_WHOLE8K  = 2'd2
    } map_mode_e;

    localparam int MODE_WHOLE_BIT   = 6;
    localparam int MODE_NOLATCH_BIT = 5;
    localparam int MODE_SMALL_BIT   = 4;
    localparam int EXT_ON_BIT       = 1;
    localparam int CTRL_SWAP_BIT    = 7;

    // Extended-mode window slot -> slot register index
    function automatic logic [2:0] ext_slot_map(input logic [2:0] slot);
        logic [2:0] r;
        unique case (slot)
            3'd0: r = 3'd0;
            3'd1: r = 3'd6;
            3'd2: r = 3'd1;
            3'd3: r = 3'd7;
            3'd4: r = 3'd2;
            3'd5: r = 3'd3;
            3'd6: r = 3'd4;
            default: r = 3'd5;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/chr_mode_decode.sv
module chr_mode_decode
    import chr_bank_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic [7:0]        mode_reg,
    input  logic [7:0]        ext_reg,
    input  logic              latch_present,
    output map_mode_e         map_mode,
    output logic [BANK_W-1:0] inner_mask,
    output logic [BANK_W-1:0] latch_mask
);
    localparam logic [BANK_W-1:0] FULL_MASK  = {BANK_W{1'b1}};
    localparam logic [BANK_W-1:0] SMALL_MASK = {1'b0, {(BANK_W-1){1'b1}}};
    localparam logic [BANK_W-1:0] LATCH_ONE  = BANK_W'(1);
    localparam logic [BANK_W-1:0] LATCH_TWO  = BANK_W'(3);

    always_comb begin
        if (mode_reg[MODE_WHOLE_BIT])
            map_mode = MAP_WHOLE8K;
        else if (ext_reg[EXT_ON_BIT])
            map_mode = MAP_EXTENDED;
        else
            map_mode = MAP_NORMAL;
    end

    always_comb begin
        inner_mask = FULL_MASK;
        latch_mask = '0;
        unique case (map_mode)
            MAP_WHOLE8K: begin
                if (latch_present && !mode_reg[MODE_NOLATCH_BIT])
                    latch_mask = mode_reg[MODE_SMALL_BIT] ? LATCH_ONE : LATCH_TWO;
            end
            MAP_EXTENDED, MAP_NORMAL: begin
                inner_mask = mode_reg[MODE_SMALL_BIT] ? SMALL_MASK : FULL_MASK;
            end
            default: begin
                inner_mask = FULL_MASK;
            end
        endcase
    end
endmodule

// File: rtl/chr_whole_base.sv
module chr_whole_base #(
    parameter int BANK_W = 8
) (
    input  logic [BANK_W-1:0] outer_bank,
    input  logic [BANK_W-1:0] data_latch,
    input  logic [BANK_W-1:0] latch_mask,
    input  logic              or_variant,
    output logic [BANK_W-1:0] whole_base
);
    logic [BANK_W-1:0] latch_bits;

    always_comb begin
        latch_bits = data_latch & latch_mask;
        if (or_variant)
            whole_base = outer_bank | latch_bits;
        else
            whole_base = (outer_bank & ~latch_mask) | latch_bits;
    end
endmodule

// File: rtl/chr_window_calc.sv
module chr_window_calc
    import chr_bank_pkg::*;
#(
    parameter int BANK_W   = 8,
    parameter int WIN_BITS = 3,
    parameter int WIN_IDX  = 0,
    localparam int OUT_W   = BANK_W + WIN_BITS,
    localparam int NWIN    = 1 << WIN_BITS
) (
    input  map_mode_e                    map_mode,
    input  logic                         swap_halves,
    input  logic [NWIN-1:0][BANK_W-1:0]  inner_regs,
    input  logic [BANK_W-1:0]            inner_mask,
    input  logic [BANK_W-1:0]            outer_bank,
    input  logic [BANK_W-1:0]            whole_base,
    output logic [OUT_W-1:0]             bank
);
    localparam logic [WIN_BITS-1:0] MY_WIN = WIN_BITS'(WIN_IDX);

    logic [WIN_BITS-1:0] slot;
    logic [BANK_W-1:0]   pick;
    logic [OUT_W-1:0]    outer_part;
    logic [OUT_W-1:0]    mask_wide;

    always_comb begin
        slot = MY_WIN ^ {swap_halves, {(WIN_BITS-1){1'b0}}};
        mask_wide  = {{WIN_BITS{1'b0}}, inner_mask};
        outer_part = {outer_bank, {WIN_BITS{1'b0}}} & ~mask_wide;
        pick = '0;
        bank = '0;
        unique case (map_mode)
            MAP_WHOLE8K: begin
                bank = {whole_base, MY_WIN};
            end
            MAP_EXTENDED: begin
                pick = inner_regs[ext_slot_map(slot)];
                bank = {{WIN_BITS{1'b0}}, pick & inner_mask} | outer_part;
            end
            MAP_NORMAL: begin
                if (slot[2])
                    pick = inner_regs[{1'b0, slot[1:0]} + 3'd2];
                else
                    pick = {inner_regs[{2'b00, slot[1]}][BANK_W-1:1], slot[0]};
                bank = {{WIN_BITS{1'b0}}, pick & inner_mask} | outer_part;
            end
            default: begin
                bank = '0;
            end
        endcase
    end
endmodule

// File: rtl/chr_bank_gen.sv
module chr_bank_gen
    import chr_bank_pkg::*;
#(
    parameter int BANK_W   = 8,
    parameter int WIN_BITS = 3,
    localparam int OUT_W   = BANK_W + WIN_BITS,
    localparam int NWIN    = 1 << WIN_BITS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NWIN-1:0][BANK_W-1:0]  inner_regs,
    input  logic [7:0]                   ctrl_reg,
    input  logic [7:0]                   mode_reg,
    input  logic [7:0]                   ext_reg,
    input  logic [BANK_W-1:0]            outer_bank,
    input  logic [BANK_W-1:0]            data_latch,
    input  logic                         latch_present,
    input  logic                         or_variant,
    input  logic [WIN_BITS-1:0]          ppu_a,
    output logic [NWIN-1:0][OUT_W-1:0]   win_bank,
    output logic [OUT_W-1:0]             bank_lookup
);
    map_mode_e                  map_mode;
    logic [BANK_W-1:0]          inner_mask;
    logic [BANK_W-1:0]          latch_mask;
    logic [BANK_W-1:0]          whole_base;
    logic [NWIN-1:0][OUT_W-1:0] bank_next;

    chr_mode_decode #(.BANK_W(BANK_W)) u_decode (
        .mode_reg      (mode_reg),
        .ext_reg       (ext_reg),
        .latch_present (latch_present),
        .map_mode      (map_mode),
        .inner_mask    (inner_mask),
        .latch_mask    (latch_mask)
    );

    chr_whole_base #(.BANK_W(BANK_W)) u_base (
        .outer_bank (outer_bank),
        .data_latch (data_latch),
        .latch_mask (latch_mask),
        .or_variant (or_variant),
        .whole_base (whole_base)
    );

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        chr_window_calc #(
            .BANK_W   (BANK_W),
            .WIN_BITS (WIN_BITS),
            .WIN_IDX  (w)
        ) u_calc (
            .map_mode    (map_mode),
            .swap_halves (ctrl_reg[CTRL_SWAP_BIT]),
            .inner_regs  (inner_regs),
            .inner_mask  (inner_mask),
            .outer_bank  (outer_bank),
            .whole_base  (whole_base),
            .bank        (bank_next[w])
        );

        AST_WHOLE_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(mode_reg[MODE_WHOLE_BIT]))
            |-> (win_bank[w][WIN_BITS-1:0] == WIN_BITS'(w))); // R7

        AST_OR_KEEPS_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(mode_reg[MODE_WHOLE_BIT]) && $past(or_variant))
            |-> ((win_bank[w][OUT_W-1:WIN_BITS] & $past(outer_bank)) == $past(outer_bank))); // R9

        AST_SMALL_MASK_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(mode_reg[MODE_WHOLE_BIT]) && $past(mode_reg[MODE_SMALL_BIT]))
            |-> (win_bank[w][OUT_W-1:BANK_W-1] == $past(outer_bank[BANK_W-1:BANK_W-1-WIN_BITS]))); // R4
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            win_bank <= '0;
        else
            win_bank <= bank_next;
    end

    always_comb begin
        bank_lookup = win_bank[ppu_a];
    end

    AST_PAIR_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mode_reg[MODE_WHOLE_BIT]) && !$past(ext_reg[EXT_ON_BIT])
         && !$past(ctrl_reg[CTRL_SWAP_BIT]))
        |-> (!win_bank[0][0] && win_bank[1] == {win_bank[0][OUT_W-1:1], 1'b1})); // R3

    AST_PAIR_SWAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mode_reg[MODE_WHOLE_BIT]) && !$past(ext_reg[EXT_ON_BIT])
         && $past(ctrl_reg[CTRL_SWAP_BIT]))
        |-> (!win_bank[4][0] && win_bank[5] == {win_bank[4][OUT_W-1:1], 1'b1})); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(!rst_n) |-> (win_bank == '0)); // R1
endmodule

// File: tb/sim_chr_bank_gen.sv
`timescale 1ns/1ps
module sim_chr_bank_gen;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0][7:0]  inner_regs = '0;
    logic [7:0]       ctrl_reg = '0;
    logic [7:0]       mode_reg = '0;
    logic [7:0]       ext_reg = '0;
    logic [7:0]       outer_bank = '0;
    logic [7:0]       data_latch = '0;
    logic             latch_present = 1'b0;
    logic             or_variant = 1'b0;
    logic [2:0]       ppu_a = '0;
    logic [7:0][10:0] win_bank;
    logic [10:0]      bank_lookup;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    chr_bank_gen u0 (
        .clk (clk), .rst_n (rst_n), .inner_regs (inner_regs),
        .ctrl_reg (ctrl_reg), .mode_reg (mode_reg), .ext_reg (ext_reg),
        .outer_bank (outer_bank), .data_latch (data_latch),
        .latch_present (latch_present), .or_variant (or_variant),
        .ppu_a (ppu_a), .win_bank (win_bank), .bank_lookup (bank_lookup)
    );

    task automatic check(input string req, input int w, input logic [10:0] act, input logic [10:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s window %0d: actual %h expected %h (mode %h ext %h ctrl %h lp %0d orv %0d)",
                     req, w, act, exp, mode_reg, ext_reg, ctrl_reg, latch_present, or_variant);
        end
    endtask

    // Expected bank from the written rules
    function automatic logic [10:0] expect_bank(input int w);
        logic [7:0]  lmask, base, v, imask;
        logic [10:0] m11;
        int slot, r;
        int ext_order[8] = '{0, 6, 1, 7, 2, 3, 4, 5};
        if (mode_reg[6]) begin
            lmask = (latch_present && !mode_reg[5]) ? (mode_reg[4] ? 8'h01 : 8'h03) : 8'h00;
            if (or_variant) base = outer_bank | (data_latch & lmask);
            else            base = (outer_bank & ~lmask) | (data_latch & lmask);
            return 11'(base) * 11'd8 + 11'(w);
        end
        slot  = ctrl_reg[7] ? (w ^ 4) : w;
        imask = mode_reg[4] ? 8'h7F : 8'hFF;
        if (ext_reg[1]) begin
            v = inner_regs[ext_order[slot]];
        end else if (slot < 4) begin
            r = slot / 2;
            v = (slot % 2 == 1) ? (inner_regs[r] | 8'h01) : (inner_regs[r] & 8'hFE);
        end else begin
            v = inner_regs[slot - 2];
        end
        m11 = {3'b000, imask};
        return ({3'b000, v} & m11) | ((11'(outer_bank) * 11'd8) & ~m11);
    endfunction

    function automatic string tag_for(input int w);
        if (mode_reg[6]) begin
            if (latch_present && !mode_reg[5]) return or_variant ? "R9" : "R8";
            return or_variant ? "R9" : "R7";
        end
        if (ext_reg[1]) return "R5";
        if (ctrl_reg[7]) return "R6";
        return (w < 4) ? "R3" : "R4";
    endfunction

    task automatic check_all();
        for (int w = 0; w < 8; w++)
            check(tag_for(w), w, win_bank[w], expect_bank(w));
        for (int a = 0; a < 8; a++) begin
            ppu_a = 3'(a);
            #0.2;
            check("R2", a, bank_lookup, win_bank[a]);
        end
    endtask

    task automatic load_pattern(input int p);
        for (int i = 0; i < 8; i++)
            inner_regs[i] = 8'((p * 53 + i * 29 + 8'h81) & 8'hFF);
        outer_bank = 8'((p * 97 + 8'h5A) & 8'hFF);
        data_latch = 8'((p * 3 + 1) & 8'hFF);
    endtask

    initial begin
        #(200000 * 10);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        // R1: reset holds all banks at zero even with live inputs
        load_pattern(5);
        mode_reg = 8'h40;
        repeat (3) @(negedge clk);
        for (int w = 0; w < 8; w++) check("R1", w, win_bank[w], 11'd0);
        check("R1", 8, bank_lookup, 11'd0);
        rst_n = 1'b1;

        // R2: one-edge latency
        @(negedge clk);
        mode_reg = 8'h00; ext_reg = 8'h00; ctrl_reg = 8'h00;
        load_pattern(1);
        @(negedge clk);
        outer_bank = outer_bank ^ 8'hF0;
        #1;
        check("R2", 7, win_bank[7], ({3'b000, inner_regs[5]}) | ((11'(outer_bank ^ 8'hF0) * 11'd8) & 11'h700));
        @(negedge clk);
        check_all();

        // Sweep over all seven configuration bits and several data patterns
        for (int p = 0; p < 4; p++) begin
            for (int cfg = 0; cfg < 128; cfg++) begin
                @(negedge clk);
                load_pattern(p);
                mode_reg      = {1'b0, cfg[0], cfg[1], cfg[2], 4'b0000} | 8'(p & 8'h0F);
                ext_reg       = {6'(p), cfg[3], 1'b0};
                ctrl_reg      = {cfg[4], 7'(p * 5)};
                or_variant    = cfg[5];
                latch_present = cfg[6];
                @(negedge clk);
                check_all();
            end
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule